// File: doc/BRIEF.md
# Coprocessor Call Stall Sequencer

This block sits on a host processor's external memory bus and turns a host access to one fixed call location into a coprocessor run. The data byte the host presents while it holds the call address becomes the argument, and the address the host moves to next is kept as the return address. The block then pulses a start request to the coprocessor. From that point the bus carries no-operation opcodes (0xEA), so the host keeps fetching and executing harmless instructions for as long as the routine runs.

Once the coprocessor raises its done level, the block waits for one more host address change. Only then does it inject an absolute jump: the opcode 0x4C, then the low byte of the return address, then the high byte. Each byte is held for one host address phase. After the high byte's phase ends, the data bus goes back to input and the block is idle again.

A busy output tells neighbouring decoders to stay silent for the whole call. A new address phase is recognised whenever the validated address value differs from the value seen on the previous clock.

Top module: `ccs_call_seq`

## Requirements
- R1: After reset, the output enable, the busy flag and the start pulse are all low.
- R2: A call begins only when a new address phase starts at address 0x1FF3. Any other address leaves busy low. While the call address is held, busy is high and the data bus stays input.
- R3: The argument is the data byte sampled at the last clock edge at which the address still read 0x1FF3.
- R4: The start output is high for exactly one clock. It rises in the clock after the address leaves 0x1FF3, and that new address is kept as the return address.
- R5: From the start pulse until done is taken, the output enable is high and the data output is 0xEA on every clock, whatever the address does. A done level seen while the start pulse is high is ignored.
- R6: Once done is taken, 0xEA stays on the bus until the next address change.
- R7: After that change, the bus carries 0x4C for one address phase, then the return address bits 7..0 for the next phase, then the return address bits 12..8 zero-extended to a byte for the phase after.
- R8: The address change that ends the high-byte phase drops the output enable in the next clock. If that new address is 0x1FF3, a new call begins at once and busy stays high. Otherwise busy falls.
- R9: Busy is high in every clock in which the output enable is high.
- R10: A phase ends only when the address value changes. While the address is steady, the byte on the bus does not advance.
- R11: If done is taken in the same clock as an address change, that change does not end the 0xEA phase. The jump opcode appears only after a later change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 13 | Validated host address |
| bus_din | input | 8 | Host data bus, sampled |
| bus_dout | output | 8 | Byte driven onto the data bus |
| bus_oe | output | 1 | Data bus output enable |
| seq_busy | output | 1 | Call in progress; neighbouring responders stay silent |
| cop_start | output | 1 | One-clock start request to the coprocessor |
| cop_arg | output | 8 | Call argument, valid with cop_start |
| cop_done | input | 1 | Coprocessor finished (level) |

## Verification
Two cases can land in the same clock.

The first is the coprocessor's done level arriving together with a host address change. The bench provokes it by stepping the address on every clock while the routine runs. It then expects 0xEA to persist across the following steady clocks, with 0x4C appearing only after a further change.

The second is the end of the high-byte phase coinciding with a fresh access to the call location. Here the output enable must drop while busy stays high and a new argument is captured. Every clock is compared against a reference model that keeps the pending jump bytes in a queue.

// File: rtl/ccs_pkg.sv
package ccs_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE  = 3'd0,
    SEQ_ARM   = 3'd1,
    SEQ_RUN   = 3'd2,
    SEQ_DRAIN = 3'd3,
    SEQ_OPC   = 3'd4,
    SEQ_LO    = 3'd5,
    SEQ_HI    = 3'd6
  } seq_state_t;

  // States in which the sequencer owns the data bus
  function automatic logic seq_drives(seq_state_t s);
    return (s == SEQ_RUN) || (s == SEQ_DRAIN) || (s == SEQ_OPC) ||
           (s == SEQ_LO)  || (s == SEQ_HI);
  endfunction

endpackage

// File: rtl/ccs_phase_edge.sv
module ccs_phase_edge #(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              phase_edge
);

  logic [ADDR_W-1:0] addr_seen;

  always_ff @(posedge clk) begin
    if (rst) addr_seen <= '0;
    else     addr_seen <= addr_in;
  end

  // any difference in the validated address opens a new phase
  assign phase_edge = (addr_in != addr_seen);

endmodule

// File: rtl/ccs_call_fsm.sv
module ccs_call_fsm
  import ccs_pkg::*;
#(
  parameter int              ADDR_W    = 13,
  parameter int              DATA_W    = 8,
  parameter logic [ADDR_W-1:0] CALL_ADDR = 13'h1FF3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic              phase_edge,
  input  logic              cop_done,
  output seq_state_t        state_q,
  output seq_state_t        state_nx,
  output logic              start_o,
  output logic [DATA_W-1:0] arg_o,
  output logic [ADDR_W-1:0] ret_o
);

  logic [DATA_W-1:0] arg_hold;
  logic              hit_call;
  logic              leave_arm;

  assign hit_call  = phase_edge && (addr_in == CALL_ADDR);
  assign leave_arm = (state_q == SEQ_ARM) && phase_edge;

  always_comb begin
    state_nx = state_q;
    unique case (state_q)
      SEQ_IDLE:  if (hit_call) state_nx = SEQ_ARM;
      SEQ_ARM:   if (phase_edge) state_nx = SEQ_RUN;
      SEQ_RUN:   if (cop_done && !start_o) state_nx = SEQ_DRAIN;
      SEQ_DRAIN: if (phase_edge) state_nx = SEQ_OPC;
      SEQ_OPC:   if (phase_edge) state_nx = SEQ_LO;
      SEQ_LO:    if (phase_edge) state_nx = SEQ_HI;
      SEQ_HI:    if (phase_edge) state_nx = hit_call ? SEQ_ARM : SEQ_IDLE;
      default:   state_nx = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= SEQ_IDLE;
      start_o  <= 1'b0;
      arg_hold <= '0;
      arg_o    <= '0;
      ret_o    <= '0;
    end else begin
      state_q <= state_nx;
      start_o <= leave_arm;
      if (state_nx == SEQ_ARM) arg_hold <= data_in;
      if (leave_arm) begin
        arg_o <= arg_hold;
        ret_o <= addr_in;
      end
    end
  end

  // R4
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    start_o |=> !start_o);

  // R4
  start_run_chk: assert property (@(posedge clk) disable iff (rst)
    start_o |-> (state_q == SEQ_RUN));

  // R3
  arg_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == SEQ_RUN && !start_o) |-> $stable(arg_o));

  // R6
  drain_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == SEQ_DRAIN && !phase_edge) |=> (state_q == SEQ_DRAIN));

  // R10
  phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((state_q == SEQ_OPC || state_q == SEQ_LO || state_q == SEQ_HI) && !phase_edge)
      |=> $stable(state_q));

endmodule

// File: rtl/ccs_bus_drive.sv
module ccs_bus_drive
  import ccs_pkg::*;
#(
  parameter int                ADDR_W = 13,
  parameter int                DATA_W = 8,
  parameter logic [DATA_W-1:0] NOP_OP = 8'hEA,
  parameter logic [DATA_W-1:0] JMP_OP = 8'h4C
) (
  input  logic              clk,
  input  logic              rst,
  input  seq_state_t        state_nx,
  input  logic [ADDR_W-1:0] ret_addr,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe
);

  logic [DATA_W-1:0] ret_lo;
  logic [DATA_W-1:0] ret_hi;

  generate
    if (ADDR_W > DATA_W) begin : g_split
      assign ret_lo = ret_addr[DATA_W-1:0];
      assign ret_hi = DATA_W'(ret_addr >> DATA_W);
    end else begin : g_narrow
      assign ret_lo = DATA_W'(ret_addr);
      assign ret_hi = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      data_oe  <= 1'b0;
      data_out <= '0;
    end else begin
      data_oe <= seq_drives(state_nx);
      unique case (state_nx)
        SEQ_RUN, SEQ_DRAIN: data_out <= NOP_OP;
        SEQ_OPC:            data_out <= JMP_OP;
        SEQ_LO:             data_out <= ret_lo;
        SEQ_HI:             data_out <= ret_hi;
        default:            data_out <= '0;
      endcase
    end
  end

endmodule

// File: rtl/ccs_call_seq.sv
module ccs_call_seq
  import ccs_pkg::*;
#(
  parameter int                ADDR_W    = 13,
  parameter int                DATA_W    = 8,
  parameter logic [ADDR_W-1:0] CALL_ADDR = 13'h1FF3,
  parameter logic [DATA_W-1:0] NOP_OP    = 8'hEA,
  parameter logic [DATA_W-1:0] JMP_OP    = 8'h4C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_din,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_oe,
  output logic              seq_busy,
  output logic              cop_start,
  output logic [DATA_W-1:0] cop_arg,
  input  logic              cop_done
);

  logic              phase_edge;
  seq_state_t        state_q;
  seq_state_t        state_nx;
  logic [ADDR_W-1:0] ret_addr;

  ccs_phase_edge #(.ADDR_W(ADDR_W)) u_edge (
    .clk        (clk),
    .rst        (rst),
    .addr_in    (bus_addr),
    .phase_edge (phase_edge)
  );

  ccs_call_fsm #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .CALL_ADDR (CALL_ADDR)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .addr_in    (bus_addr),
    .data_in    (bus_din),
    .phase_edge (phase_edge),
    .cop_done   (cop_done),
    .state_q    (state_q),
    .state_nx   (state_nx),
    .start_o    (cop_start),
    .arg_o      (cop_arg),
    .ret_o      (ret_addr)
  );

  ccs_bus_drive #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .NOP_OP (NOP_OP),
    .JMP_OP (JMP_OP)
  ) u_drive (
    .clk      (clk),
    .rst      (rst),
    .state_nx (state_nx),
    .ret_addr (ret_addr),
    .data_out (bus_dout),
    .data_oe  (bus_oe)
  );

  assign seq_busy = (state_q != SEQ_IDLE);

  // R5
  run_nop_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == SEQ_RUN) |-> (bus_oe && bus_dout == NOP_OP));

  // R7
  jmp_op_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == SEQ_OPC) |-> (bus_oe && bus_dout == JMP_OP));

  // R8
  release_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == SEQ_HI && phase_edge && bus_addr != CALL_ADDR) |=> (!bus_oe && !seq_busy));

  // R9
  oe_busy_chk: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> seq_busy);

endmodule

// File: tb/ccs_call_seq_test.sv
module ccs_call_seq_test;

  localparam int CALL = 'h1FF3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [12:0] addr = '0;
  logic [7:0]  din = '0;
  logic        done = 1'b0;
  logic [7:0]  dout;
  logic        oe;
  logic        busy;
  logic        start;
  logic [7:0]  arg;

  always #10 clk = ~clk;

  ccs_call_seq uut (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (addr),
    .bus_din   (din),
    .bus_dout  (dout),
    .bus_oe    (oe),
    .seq_busy  (busy),
    .cop_start (start),
    .cop_arg   (arg),
    .cop_done  (done)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model
  int m_mode = 0;     // 0 idle, 1 holding call address, 2 running, 3 emitting queue
  int m_prev = 0;
  int m_hold = 0;
  int m_arg = 0;
  int m_ret = 0;
  bit m_first = 0;
  bit m_start = 0;
  int m_q[$];

  // coprocessor model
  int cop_delay = 8;
  int cop_cnt = -1;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_edge(int a, int d, bit dn);
    bit chg;
    chg = (a != m_prev);
    m_start = 0;
    case (m_mode)
      0: if (chg && a == CALL) begin m_mode = 1; m_hold = d; end
      1: begin
        if (!chg) m_hold = d;
        else begin
          m_start = 1; m_arg = m_hold; m_ret = a; m_mode = 2; m_first = 1;
        end
      end
      2: begin
        if (m_first) m_first = 0;
        else if (dn) begin
          m_q.delete();
          m_q.push_back('hEA);
          m_q.push_back('h4C);
          m_q.push_back(m_ret & 'hFF);
          m_q.push_back((m_ret >> 8) & 'hFF);
          m_mode = 3;
        end
      end
      default: begin
        if (chg) begin
          void'(m_q.pop_front());
          if (m_q.size() == 0) begin
            if (a == CALL) begin m_mode = 1; m_hold = d; end
            else m_mode = 0;
          end
        end
      end
    endcase
    m_prev = a;
  endtask

  task automatic compare;
    string t;
    if (m_mode == 2) t = "R5";
    else if (m_mode == 3 && m_q.size() == 4) t = "R6 R11";
    else if (m_mode == 3) t = "R7";
    else t = "R8";
    chk("R4 start", int'(start), int'(m_start));
    if (m_start) chk("R3 argument", int'(arg), m_arg);
    chk({t, " oe"}, int'(oe), (m_mode >= 2) ? 1 : 0);
    if (m_mode == 2) chk({t, " data"}, int'(dout), 'hEA);
    if (m_mode == 3) chk({t, " data"}, int'(dout), m_q[0]);
    chk("R9 busy", int'(busy), (m_mode != 0) ? 1 : 0);
  endtask

  task automatic cyc(int a, int d);
    bit dn;
    addr = 13'(a);
    din  = 8'(d);
    @(posedge clk);
    dn = done;
    #2;
    if (rst) begin
      m_mode = 0; m_prev = 0; m_start = 0; m_q.delete();
    end else begin
      model_edge(a, d, dn);
      compare();
    end
    if (start) begin
      done = 1'b0;
      cop_cnt = cop_delay;
      if (cop_delay == 0) done = 1'b1;
    end else if (cop_cnt > 0) begin
      cop_cnt--;
      if (cop_cnt == 0) done = 1'b1;
    end
  endtask

  task automatic run_out(int base, int div);
    for (int i = 0; i < 1000 && m_mode == 2; i++) cyc(base + i / div, 0);
  endtask

  initial begin
    int cur;
    for (int i = 0; i < 3; i++) cyc(0, 0);
    rst = 1'b0;
    cyc(0, 0);
    chk("R1 oe after reset", int'(oe), 0);
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 start after reset", int'(start), 0);

    // idle traffic: no call
    cyc('h1000, 1); cyc('h1FF2, 5); cyc('h1FF4, 6); cyc('h1FF4, 7);
    chk("R2 busy on other address", int'(busy), 0);

    // call with argument captured from the last held cycle
    cyc(CALL, 'h11);
    chk("R2 busy on call", int'(busy), 1);
    chk("R2 bus input on call", int'(oe), 0);
    cyc(CALL, 'h22); cyc(CALL, 'h37);
    cyc('h1ABC, 'h99);
    chk("R4 start pulse", int'(start), 1);
    chk("R3 last byte argument", int'(arg), 'h37);
    cop_delay = 8;
    run_out('h1ABC, 2);
    cur = int'(addr);
    for (int i = 0; i < 5; i++) cyc(cur, 0);
    chk("R10 steady address keeps nop", int'(dout), 'hEA);
    chk("R6 oe in drain", int'(oe), 1);
    cyc('h0300, 0); cyc('h0300, 0);
    chk("R7 jump opcode", int'(dout), 'h4C);
    cyc('h0301, 0); cyc('h0301, 0);
    chk("R7 low byte", int'(dout), 'hBC);
    cyc('h0302, 0); cyc('h0302, 0);
    chk("R7 high byte", int'(dout), 'h1A);
    cyc('h0303, 0);
    chk("R8 oe released", int'(oe), 0);
    chk("R8 busy released", int'(busy), 0);

    // done coincides with an address change
    cyc(CALL, 'h5C);
    cyc('h0F80, 0);
    cop_delay = 5;
    run_out('h0F80, 1);
    cur = int'(addr);
    cyc(cur, 0); cyc(cur, 0);
    chk("R11 nop held after coincident change", int'(dout), 'hEA);
    cyc(cur + 7, 0);
    chk("R11 opcode after later change", int'(dout), 'h4C);
    cyc(cur + 8, 0); cyc(cur + 9, 0); cyc(cur + 10, 0);

    // done already high during start pulse; back-to-back call
    cop_delay = 0;
    cyc(CALL, 'h5A); cyc(CALL, 'hA5);
    cyc('h1234, 0);
    chk("R3 argument second call", int'(arg), 'hA5);
    cyc('h1234, 0);
    chk("R5 nop during start cycle", int'(dout), 'hEA);
    chk("R5 oe during start cycle", int'(oe), 1);
    cyc('h1234, 0);
    cyc('h1235, 0); cyc('h1236, 0); cyc('h1237, 0);
    chk("R7 high byte 0x12", int'(dout), 'h12);
    cyc(CALL, 'h77);
    chk("R8 oe off on direct recall", int'(oe), 0);
    chk("R8 busy held on direct recall", int'(busy), 1);
    cop_delay = 3;
    cyc('h0042, 0);
    chk("R3 argument of recall", int'(arg), 'h77);
    run_out('h0042, 3);
    cur = int'(addr);
    cyc(cur + 1, 0); cyc(cur + 2, 0);
    chk("R7 low byte 0x42", int'(dout), 'h42);
    cyc(cur + 3, 0);
    chk("R7 high byte zero", int'(dout), 'h00);
    cyc(cur + 4, 0); cyc(cur + 4, 0);
    chk("R8 idle after return", int'(busy), 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R8 watchdog actual=hung expected=complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule